// File: doc/BRIEF.md
# Handshake-Terminated Bus Cycle Sequencer

This block is the master side of an external bus whose cycles end when the addressed device answers. A host presents a request: address, function code, a read/write flag, a byte/word size and write data. The sequencer then runs one bus cycle, or two for a word, across a fixed chain of half-clock states. It drives the function code, the address with its enable, one strobe for the address and one for the data, the R/W line and the output enable for write data. It samples a device acknowledge and a bus-error input, and inserts whole-clock wait states until one of them arrives.

The core runs on a single clock. Each core clock is one half-state of the bus, and the block generates the bus clock as a toggle of that clock. A bus state is even when the bus clock is high, so even states begin on a rising bus edge and odd states on a falling one. The external data path is one byte wide. A word access becomes two byte cycles: the high byte goes to the even address first, then the low byte to the odd address. Completion comes back to the host as a single-cycle pulse with an error flag and the assembled read data.

Top module: `busCycleSeq`

## Requirements
- R1: In reset and while idle, the sequencer holds busAs=0, busDs=0, busRw=1, busAddrOe=0, busDoe=0, busFc=0 and rspDone=0.
- R2: busClk inverts on every core clock. reqReady is high only while idle with busClk low. A request is accepted on the clock edge where reqValid and reqReady are both high, and the next core cycle is state S0 with busClk high.
- R3: A cycle counts states S0..S7 from acceptance, one core clock each. From S0 onward busFc carries the request code. busAddrOe and busAddr are valid from S1 onward. busAs and busDs are high from S2 through S6, and busRw stays 1 for a read.
- R4: The sequencer samples busAck and busErr at the end of S4. If neither is high, it inserts pairs of wait half-states, one full bus clock each, and samples again at the end of each pair. Each pair adds 2 core clocks, and the address, function code, strobes and R/W are held throughout.
- R5: For a write, busRw is 0 from S2 until the cycle ends. busDoe is high with the write byte on busDout from S3 through S6, and is low once the strobes drop.
- R6: For a word, busAddr bit 0 is forced to 0 for the first byte cycle and 1 for the second. A write sends reqWdata[15:8] first and reqWdata[7:0] second. A read places the first byte in rspRdata[15:8] and the second in rspRdata[7:0].
- R7: A byte read latches busDin at the end of S6 and returns it as rspRdata = {8'h00, byte}. Without wait states, rspDone rises 8 core clocks after acceptance for a byte and 16 for a word.
- R8: If busErr is sampled high with busAck low, the cycle is extended by S8 and S9 (2 core clocks more). rspDone and rspErr then pulse together. For a word, the second byte cycle is not run.
- R9: If busAck and busErr are sampled high together, the cycle ends normally and rspErr=0.
- R10: rspDone is a one-cycle pulse. rspErr is only high together with rspDone. busAddrOe is 0 in the core cycle that carries rspDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one bus half-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted this edge if reqValid is high |
| reqAddr | input | ADDR_W | Byte address |
| reqFc | input | FC_W | Function code for the cycle |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqWdata | input | 2*BYTE_W | Write data (byte in low half) |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Bus error flag, valid with rspDone |
| rspRdata | output | 2*BYTE_W | Assembled read data |
| busClk | output | 1 | Generated bus clock |
| busFc | output | FC_W | Function code lines |
| busAddr | output | ADDR_W | Address lines |
| busAddrOe | output | 1 | Address drive enable |
| busAs | output | 1 | Address strobe, active high |
| busDs | output | 1 | Data strobe, active high |
| busRw | output | 1 | 1 = read, 0 = write |
| busDout | output | BYTE_W | Write data lines |
| busDoe | output | 1 | Write data drive enable |
| busDin | input | BYTE_W | Read data lines |
| busAck | input | 1 | Device acknowledge |
| busErr | input | 1 | Bus error |

## Verification
Each bus result falls at a fixed count of core clocks after the acceptance edge. The function code is due in S0 (count 0), the address in S1 and the strobes in S2. Write data is due in S3. Done is due at 8 per byte cycle, plus 2 for each wait pair and 2 for a bus-error termination. The bench counts rising edges from acceptance and samples every output on the following falling edge. It compares the done position with the count computed from the request's size, the modeled device's wait setting and its error mode. The modeled device raises its answer after a chosen number of core clocks of strobe, so the number of wait pairs is known in advance.

// File: rtl/busCycleSeq_pkg.sv
package busCycleSeq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_W1, ST_W2,
    ST_S5, ST_S6, ST_S7, ST_S8, ST_S9
  } seqState_t;

  typedef struct packed {
    logic load;     // capture the host request
    logic second;   // second byte of a split word
    logic fcEn;     // drive function code
    logic addrEn;   // drive address
    logic dataEn;   // drive write byte
    logic latch;    // capture read byte
  } ctrlStrb_t;

endpackage

// File: rtl/busCycleSeqCtrl.sv
module busCycleSeqCtrl
  import busCycleSeq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqRead,
  input  logic      reqWord,
  input  logic      busAck,
  input  logic      busErr,
  output logic      reqReady,
  output logic      rspDone,
  output logic      rspErr,
  output logic      busClk,
  output logic      busAs,
  output logic      busDs,
  output logic      busRw,
  output ctrlStrb_t strb
);

  seqState_t st;
  logic phase;
  logic readQ, wordQ, secondQ, termErrQ;
  logic doneQ, errQ;
  logic inStrobe, inAddr, inWrData, inRwLow, sampleNow, lastByte;

  always_comb begin
    inStrobe  = (st == ST_S2) || (st == ST_S3) || (st == ST_S4) || (st == ST_W1) ||
                (st == ST_W2) || (st == ST_S5) || (st == ST_S6);
    inWrData  = !readQ && (inStrobe && (st != ST_S2));
    inRwLow   = !readQ && (inStrobe || (st == ST_S7) || (st == ST_S8) || (st == ST_S9));
    inAddr    = (st != ST_IDLE) && (st != ST_S0);
    sampleNow = (st == ST_S4) || (st == ST_W2);
    lastByte  = !wordQ || secondQ;
  end

  assign reqReady = (st == ST_IDLE) && !phase;
  assign busClk   = phase;
  assign busAs    = inStrobe;
  assign busDs    = inStrobe;
  assign busRw    = !inRwLow;
  assign rspDone  = doneQ;
  assign rspErr   = errQ;

  always_comb begin
    strb.load   = reqReady && reqValid;
    strb.second = secondQ;
    strb.fcEn   = (st != ST_IDLE);
    strb.addrEn = inAddr;
    strb.dataEn = inWrData;
    strb.latch  = (st == ST_S6) && readQ && !termErrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      phase    <= 1'b0;
      readQ    <= 1'b1;
      wordQ    <= 1'b0;
      secondQ  <= 1'b0;
      termErrQ <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      phase <= ~phase;
      doneQ <= ((st == ST_S7) && !termErrQ && lastByte) || (st == ST_S9);
      errQ  <= (st == ST_S9);
      case (st)
        ST_IDLE: if (reqValid && !phase) begin
          st       <= ST_S0;
          readQ    <= reqRead;
          wordQ    <= reqWord;
          secondQ  <= 1'b0;
          termErrQ <= 1'b0;
        end
        ST_S0: st <= ST_S1;
        ST_S1: st <= ST_S2;
        ST_S2: st <= ST_S3;
        ST_S3: st <= ST_S4;
        ST_S4, ST_W2: begin
          if (sampleNow && (busAck || busErr)) begin
            termErrQ <= busErr && !busAck;
            st       <= ST_S5;
          end else begin
            st <= ST_W1;
          end
        end
        ST_W1: st <= ST_W2;
        ST_S5: st <= ST_S6;
        ST_S6: st <= ST_S7;
        ST_S7: begin
          if (termErrQ) st <= ST_S8;
          else if (!lastByte) begin
            st      <= ST_S0;
            secondQ <= 1'b1;
          end else st <= ST_IDLE;
        end
        ST_S8: st <= ST_S9;
        ST_S9: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/busCycleSeqData.sv
module busCycleSeqData
  import busCycleSeq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic              reqWord,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [BYTE_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic [FC_W-1:0]   busFc,
  output logic [BYTE_W-1:0] busDout,
  output logic              busDoe,
  output logic [WORD_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [FC_W-1:0]   fcQ;
  logic [WORD_W-1:0] wdataQ;
  logic              wordQ;
  logic [WORD_W-1:0] rdQ;
  logic              a0;
  logic [BYTE_W-1:0] wrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      fcQ    <= '0;
      wdataQ <= '0;
      wordQ  <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        fcQ    <= reqFc;
        wdataQ <= reqWdata;
        wordQ  <= reqWord;
      end
      if (strb.latch) begin
        if (!wordQ)            rdQ <= {{BYTE_W{1'b0}}, busDin};
        else if (!strb.second) rdQ[WORD_W-1:BYTE_W] <= busDin;
        else                   rdQ[BYTE_W-1:0] <= busDin;
      end
    end
  end

  always_comb begin
    a0     = wordQ ? strb.second : addrQ[0];
    wrByte = (wordQ && !strb.second) ? wdataQ[WORD_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];
  end

  assign busAddr   = strb.addrEn ? {addrQ[ADDR_W-1:1], a0} : '0;
  assign busAddrOe = strb.addrEn;
  assign busFc     = strb.fcEn ? fcQ : '0;
  assign busDout   = strb.dataEn ? wrByte : '0;
  assign busDoe    = strb.dataEn;
  assign rspRdata  = rdQ;

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busCycleSeq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [FC_W-1:0]       reqFc,
  input  logic                  reqRead,
  input  logic                  reqWord,
  input  logic [2*BYTE_W-1:0]   reqWdata,
  output logic                  rspDone,
  output logic                  rspErr,
  output logic [2*BYTE_W-1:0]   rspRdata,
  output logic                  busClk,
  output logic [FC_W-1:0]       busFc,
  output logic [ADDR_W-1:0]     busAddr,
  output logic                  busAddrOe,
  output logic                  busAs,
  output logic                  busDs,
  output logic                  busRw,
  output logic [BYTE_W-1:0]     busDout,
  output logic                  busDoe,
  input  logic [BYTE_W-1:0]     busDin,
  input  logic                  busAck,
  input  logic                  busErr
);

  ctrlStrb_t strb;

  busCycleSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead), .reqWord(reqWord),
    .busAck(busAck), .busErr(busErr), .reqReady(reqReady), .rspDone(rspDone),
    .rspErr(rspErr), .busClk(busClk), .busAs(busAs), .busDs(busDs), .busRw(busRw),
    .strb(strb)
  );

  busCycleSeqData #(.ADDR_W(ADDR_W), .FC_W(FC_W), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqFc(reqFc),
    .reqWord(reqWord), .reqWdata(reqWdata), .busDin(busDin), .busAddr(busAddr),
    .busAddrOe(busAddrOe), .busFc(busFc), .busDout(busDout), .busDoe(busDoe),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/busCycleSeqChk.sv
module busCycleSeqChk #(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busClk,
  input logic              busAs,
  input logic              busDs,
  input logic              busRw,
  input logic              busAddrOe,
  input logic              busDoe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [FC_W-1:0]   busFc,
  input logic              rspDone,
  input logic              rspErr
);

  // R2: bus clock inverts every core clock once out of reset
  a_r2_clk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (busClk != $past(busClk)));

  // R2, R3: strobes rise at the start of an even state only
  a_r3_strobe_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAs) |-> busClk);

  // R3: address driven before the strobe rises
  a_r3_addr_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAs) |-> $past(busAddrOe));

  // R3: both strobes move together
  a_r3_strobes_pair: assert property (@(posedge clk) disable iff (!rstN)
    busAs == busDs);

  // R4: bus held while strobes stay up (covers wait states)
  a_r4_hold_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    (busAs && $past(busAs)) |-> ($stable(busAddr) && $stable(busFc) && $stable(busRw)));

  // R5: write data only within a write strobe
  a_r5_doe_in_write: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> (busAs && !busRw));

  // R10: single-cycle done
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R10: error only with done, address released at done
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);

  a_r10_addr_released: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !busAddrOe);

endmodule

bind busCycleSeq busCycleSeqChk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
  .clk(clk), .rstN(rstN), .busClk(busClk), .busAs(busAs), .busDs(busDs),
  .busRw(busRw), .busAddrOe(busAddrOe), .busDoe(busDoe), .busAddr(busAddr),
  .busFc(busFc), .rspDone(rspDone), .rspErr(rspErr)
);

// File: tb/sim_busCycleSeq.sv
`timescale 1ns/1ps
module sim_busCycleSeq;
  localparam int ADDR_W = 24;
  localparam int FC_W   = 3;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [FC_W-1:0] reqFc = '0;
  logic reqRead = 1'b1, reqWord = 1'b0;
  logic [15:0] reqWdata = '0;
  logic rspDone, rspErr;
  logic [15:0] rspRdata;
  logic busClk, busAddrOe, busAs, busDs, busRw, busDoe;
  logic [FC_W-1:0] busFc;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busDout, busDin;
  logic busAck = 1'b0, busErr = 1'b0;

  always #2 clk = ~clk;

  busCycleSeq u0 (.*);

  int checks = 0, fails = 0;
  int devWaits = 0, devMode = 0;  // mode 0 ack, 1 err only, 2 ack and err
  int asCnt = 0;
  int wrCount = 0;
  logic [ADDR_W-1:0] wrAddr [4];
  logic [7:0] wrData [4];
  logic prevDoe = 1'b0;

  assign busDin = busAddr[7:0] ^ 8'h5A;  // device memory content

  always @(posedge clk) asCnt <= busAs ? asCnt + 1 : 0;

  always @(negedge clk) begin
    logic hit;
    hit = busAs && (asCnt >= 2 + 2 * devWaits);
    busAck <= hit && (devMode != 1);
    busErr <= hit && (devMode != 0);
    if (busDoe && !prevDoe && wrCount < 4) begin
      wrAddr[wrCount] = busAddr;
      wrData[wrCount] = busDout;
      wrCount = wrCount + 1;
    end
    prevDoe = busDoe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one request; returns core clocks from acceptance to done
  task automatic runReq(input logic rd, input logic wd, input logic [ADDR_W-1:0] a,
                        input logic [FC_W-1:0] fc, input logic [15:0] wdat,
                        input int waits, input int mode, output int lat);
    int n;
    devWaits = waits; devMode = mode; wrCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqWord = wd; reqAddr = a; reqFc = fc; reqWdata = wdat;
    n = 0;
    while (!reqReady && n < 10) begin @(negedge clk); n++; end
    chk("R2 ready only with bus clock low", {31'd0, busClk}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    chk("R2 S0 bus clock high", {31'd0, busClk}, 32'd1);
    chk("R3 fc in S0", {29'd0, busFc}, {29'd0, fc});
    chk("R3 no address in S0", {31'd0, busAddrOe}, 32'd0);
    while (!rspDone && n < 200) begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 1) begin
        chk("R3 address in S1", {31'd0, busAddrOe}, 32'd1);
        chk("R6 address value", busAddr, wd ? {a[ADDR_W-1:1], 1'b0} : a);
        chk("R3 no strobe in S1", {31'd0, busAs}, 32'd0);
      end
      if (n == 2) begin
        chk("R3 strobes in S2", {30'd0, busAs, busDs}, 32'd3);
        chk("R5 rw in S2", {31'd0, busRw}, {31'd0, rd});
      end
      if (n == 3 && !rd) chk("R5 data enable in S3", {31'd0, busDoe}, 32'd1);
    end
    lat = n;
  endtask

  task automatic tReset();
    chk("R1 as idle", {31'd0, busAs}, 32'd0);
    chk("R1 rw idle", {31'd0, busRw}, 32'd1);
    chk("R1 addr oe idle", {31'd0, busAddrOe}, 32'd0);
    chk("R1 doe idle", {31'd0, busDoe}, 32'd0);
    chk("R1 fc idle", {29'd0, busFc}, 32'd0);
    chk("R1 done idle", {31'd0, rspDone}, 32'd0);
  endtask

  task automatic tByteRead();
    int lat;
    runReq(1'b1, 1'b0, 24'h001235, 3'd5, 16'h0, 0, 0, lat);
    chk("R7 byte read latency", lat, 8);
    chk("R7 byte read data", rspRdata, {8'h00, 8'h35 ^ 8'h5A});
    chk("R10 error low", {31'd0, rspErr}, 32'd0);
    chk("R10 addr released at done", {31'd0, busAddrOe}, 32'd0);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, rspDone}, 32'd0);
  endtask

  task automatic tByteWrite();
    int lat;
    runReq(1'b0, 1'b0, 24'h00ABC1, 3'd1, 16'h77C3, 0, 0, lat);
    chk("R5 byte write latency", lat, 8);
    chk("R5 one write cycle", wrCount, 1);
    chk("R5 write byte", wrData[0], 8'hC3);
    chk("R5 write addr", wrAddr[0], 24'h00ABC1);
  endtask

  task automatic tWaitRead();
    int lat;
    runReq(1'b1, 1'b0, 24'h000010, 3'd2, 16'h0, 2, 0, lat);
    chk("R4 two wait pairs latency", lat, 12);
    chk("R4 data after waits", rspRdata, {8'h00, 8'h10 ^ 8'h5A});
  endtask

  task automatic tWordWrite();
    int lat;
    runReq(1'b0, 1'b1, 24'h000201, 3'd6, 16'hBEEF, 0, 0, lat);
    chk("R7 word latency", lat, 16);
    chk("R6 two write cycles", wrCount, 2);
    chk("R6 high byte first", wrData[0], 8'hBE);
    chk("R6 even address first", wrAddr[0], 24'h000200);
    chk("R6 low byte second", wrData[1], 8'hEF);
    chk("R6 odd address second", wrAddr[1], 24'h000201);
  endtask

  task automatic tWordRead();
    int lat;
    runReq(1'b1, 1'b1, 24'h000344, 3'd3, 16'h0, 1, 0, lat);
    chk("R4 word with one wait pair latency", lat, 20);
    chk("R6 word read assembly", rspRdata, {8'h44 ^ 8'h5A, 8'h45 ^ 8'h5A});
  endtask

  task automatic tErrByte();
    int lat;
    runReq(1'b1, 1'b0, 24'h000050, 3'd1, 16'h0, 0, 1, lat);
    chk("R8 error latency", lat, 10);
    chk("R8 error flag", {31'd0, rspErr}, 32'd1);
  endtask

  task automatic tErrWord();
    int lat;
    runReq(1'b0, 1'b1, 24'h000400, 3'd1, 16'h1234, 1, 1, lat);
    chk("R8 word error latency", lat, 12);
    chk("R8 second byte aborted", wrCount, 1);
    chk("R8 error flag word", {31'd0, rspErr}, 32'd1);
  endtask

  task automatic tAckAndErr();
    int lat;
    runReq(1'b1, 1'b0, 24'h000061, 3'd4, 16'h0, 0, 2, lat);
    chk("R9 both inputs latency", lat, 8);
    chk("R9 no error", {31'd0, rspErr}, 32'd0);
    chk("R9 data", rspRdata, {8'h00, 8'h61 ^ 8'h5A});
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tByteRead();
    tByteWrite();
    tWaitRead();
    tWordWrite();
    tWordRead();
    tErrByte();
    tErrWord();
    tAckAndErr();
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule